// File: doc/BRIEF.md
# ATA Status Wait Engine

This block waits for an ATA device to become ready. It polls the device status register through a taskfile register port and gives the verdict to the controller logic that drives it. The controller uses it before it issues a command and before it pushes PIO data out. A pulse on `start` launches a wait. The block pauses briefly and then reads status over and over until the busy flag drops. At first the reads are spaced closely. Once the elapsed time passes a limit, the spacing becomes coarse. The whole busy phase has a fixed time budget.

If the status comes back as all ones, the block selects the drive again once and retries the read after a short pause. When the busy flag has dropped, the block can optionally wait for a requested set of status bits. This second phase has a short, count-limited poll loop of its own.

All delays are counted in pulses of `tick_us`, one pulse per microsecond. Each wait ends with a one-cycle `done` pulse. `fail` and `err_bit` hold the verdict until the next start.

Top module: `ata_status_waiter`

## Requirements
- R1: Out of reset, `done`, `fail`, `err_bit`, `tf_rd` and `tf_wr` are all low.
- R2: After an accepted `start`, the first status read comes only after SETTLE_US microsecond ticks have passed.
- R3: Busy is status bit 7. When a read shows it clear and the wanted mask is zero, the operation ends with `fail`=0 and `err_bit` equal to status bit 0 of that read.
- R4: While the busy bit stays set, the gap before the next read is FAST_STEP_US ticks if the elapsed time is at most FAST_LIMIT_US, and SLOW_STEP_US ticks otherwise. The elapsed time grows by the gap just chosen.
- R5: If the grown elapsed time reaches BUSY_BUDGET_US, the operation ends at once with `fail`=1 and `err_bit`=0.
- R6: If a status read returns 0xFF, the block writes 0xA0 | (unit_sel << 4) to drive register address 6. It waits RESEL_US ticks and then reads again. A second 0xFF ends with `fail`=1. Any other value is then handled as a normal status.
- R7: With a nonzero mask, once busy has cleared the block waits SETTLE_US ticks. It then reads up to BIT_POLLS times, BIT_STEP_US ticks apart. The first read that has every mask bit set ends with `fail`=0 and `err_bit` equal to status bit 0 of that read.
- R8: If none of the BIT_POLLS reads matches the mask, the operation ends with `fail`=1 and `err_bit`=0 right after the last read.
- R9: `done` is high for exactly one cycle per operation. A `start` that arrives while an operation is running is ignored.
- R10: Every status read drives `tf_addr`=7. Reads and writes never share a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| start | input | 1 | Launches a wait when idle |
| want_mask | input | 8 | Status bits required in phase two (zero skips phase two) |
| unit_sel | input | 1 | Drive number used for reselection |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Timeout or dead-bus verdict |
| err_bit | output | 1 | Status error bit seen on success |
| tf_rd | output | 1 | Taskfile read strobe, data sampled the same cycle |
| tf_wr | output | 1 | Taskfile write strobe |
| tf_addr | output | 3 | Taskfile register address |
| tf_wdata | output | 8 | Taskfile write data |
| tf_rdata | input | 8 | Taskfile read data |

## Verification
The bench builds the engine with a 30 us busy budget, a fast-step limit of 6 us, gaps of 2 and 5 us, a 3 us reselect pause and four mask polls of 2 us. It pulses the tick every third cycle. With these values the switch from fine to coarse spacing, the budget expiry and the exhaustion of the mask polls each happen within about a hundred cycles. The scoreboard therefore checks the tick count before every read across all of these paths, as well as the reselect write and both all-ones outcomes.

// File: rtl/ata_wait_pkg.sv
package ata_wait_pkg;

    localparam logic [2:0] STATUS_REG = 3'd7;
    localparam logic [2:0] DRIVE_REG  = 3'd6;
    localparam logic [7:0] SEL_BASE   = 8'hA0;
    localparam int         BUSY_BIT   = 7;
    localparam int         ERR_BIT    = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE1,
        ST_RD_BUSY,
        ST_RESEL_WR,
        ST_RESEL_WAIT,
        ST_RD_RESEL,
        ST_GAP,
        ST_SETTLE2,
        ST_RD_BITS,
        ST_GAP2
    } wait_state_e;

endpackage

// File: rtl/ata_us_timer.sv
module ata_us_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         fire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // expires on the tick that consumes the last microsecond
    assign fire = !load && tick && (cnt_q == W'(1));
endmodule

// File: rtl/ata_busy_pacer.sv
module ata_busy_pacer #(
    parameter int EW            = 24,
    parameter int TW            = 11,
    parameter int FAST_LIMIT_US = 1000,
    parameter int FAST_STEP_US  = 10,
    parameter int SLOW_STEP_US  = 1000,
    parameter int BUDGET_US     = 5000000
) (
    input  logic [EW-1:0] elapsed,
    output logic [TW-1:0] gap,
    output logic [EW-1:0] elapsed_next,
    output logic          over_budget
);
    logic [EW-1:0] gap_w;

    always_comb begin
        gap_w        = (elapsed > EW'(FAST_LIMIT_US)) ? EW'(SLOW_STEP_US) : EW'(FAST_STEP_US);
        elapsed_next = elapsed + gap_w;
        over_budget  = (elapsed_next >= EW'(BUDGET_US));
        gap          = gap_w[TW-1:0];
    end
endmodule

// File: rtl/ata_status_eval.sv
module ata_status_eval
    import ata_wait_pkg::*;
(
    input  logic [7:0] status,
    input  logic [7:0] mask,
    output logic       all_ones,
    output logic       busy,
    output logic       match,
    output logic       err
);
    assign all_ones = (status == 8'hFF);
    assign busy     = status[BUSY_BIT];
    assign match    = ((status & mask) == mask);
    assign err      = status[ERR_BIT];
endmodule

// File: rtl/ata_status_waiter.sv
module ata_status_waiter
    import ata_wait_pkg::*;
#(
    parameter int SETTLE_US      = 1,
    parameter int RESEL_US       = 10,
    parameter int FAST_STEP_US   = 10,
    parameter int SLOW_STEP_US   = 1000,
    parameter int FAST_LIMIT_US  = 1000,
    parameter int BUSY_BUDGET_US = 5000000,
    parameter int BIT_POLLS      = 5000,
    parameter int BIT_STEP_US    = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       start,
    input  logic [7:0] want_mask,
    input  logic       unit_sel,
    output logic       done,
    output logic       fail,
    output logic       err_bit,
    output logic       tf_rd,
    output logic       tf_wr,
    output logic [2:0] tf_addr,
    output logic [7:0] tf_wdata,
    input  logic [7:0] tf_rdata
);
    localparam int MAX_A   = (SLOW_STEP_US > FAST_STEP_US) ? SLOW_STEP_US : FAST_STEP_US;
    localparam int MAX_B   = (RESEL_US > BIT_STEP_US) ? RESEL_US : BIT_STEP_US;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ST  = (MAX_AB > SETTLE_US) ? MAX_AB : SETTLE_US;
    localparam int TW      = $clog2(MAX_ST + 1);
    localparam int EW      = $clog2(BUSY_BUDGET_US + MAX_A + 1);
    localparam int PW      = $clog2(BIT_POLLS + 1);

    typedef struct packed {
        wait_state_e   state;
        logic [EW-1:0] elapsed;
        logic [PW-1:0] polls;
        logic [7:0]    mask;
        logic          unit;
        logic          done;
        logic          fail;
        logic          err;
    } waiter_t;

    waiter_t st_d, st_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_fire;
    logic [TW-1:0] pace_gap;
    logic [EW-1:0] pace_next;
    logic          pace_over;
    logic          ev_ones, ev_busy, ev_match, ev_err;

    ata_us_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_us),
        .fire     (tmr_fire)
    );

    ata_busy_pacer #(
        .EW            (EW),
        .TW            (TW),
        .FAST_LIMIT_US (FAST_LIMIT_US),
        .FAST_STEP_US  (FAST_STEP_US),
        .SLOW_STEP_US  (SLOW_STEP_US),
        .BUDGET_US     (BUSY_BUDGET_US)
    ) u_pacer (
        .elapsed      (st_q.elapsed),
        .gap          (pace_gap),
        .elapsed_next (pace_next),
        .over_budget  (pace_over)
    );

    ata_status_eval u_eval (
        .status   (tf_rdata),
        .mask     (st_q.mask),
        .all_ones (ev_ones),
        .busy     (ev_busy),
        .match    (ev_match),
        .err      (ev_err)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tf_rd     = 1'b0;
        tf_wr     = 1'b0;
        tf_addr   = STATUS_REG;
        tf_wdata  = '0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.mask    = want_mask;
                    st_d.unit    = unit_sel;
                    st_d.elapsed = '0;
                    st_d.polls   = '0;
                    st_d.fail    = 1'b0;
                    st_d.err     = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(SETTLE_US);
                    st_d.state   = ST_SETTLE1;
                end
            end
            ST_SETTLE1: if (tmr_fire) st_d.state = ST_RD_BUSY;
            ST_GAP:     if (tmr_fire) st_d.state = ST_RD_BUSY;
            ST_RESEL_WAIT: if (tmr_fire) st_d.state = ST_RD_RESEL;
            ST_SETTLE2: if (tmr_fire) st_d.state = ST_RD_BITS;
            ST_GAP2:    if (tmr_fire) st_d.state = ST_RD_BITS;
            ST_RESEL_WR: begin
                tf_wr      = 1'b1;
                tf_addr    = DRIVE_REG;
                tf_wdata   = SEL_BASE | {3'b000, st_q.unit, 4'b0000};
                tmr_load   = 1'b1;
                tmr_val    = TW'(RESEL_US);
                st_d.state = ST_RESEL_WAIT;
            end
            ST_RD_BUSY, ST_RD_RESEL: begin
                tf_rd = 1'b1;
                if (ev_ones && st_q.state == ST_RD_BUSY) begin
                    st_d.state = ST_RESEL_WR;
                end else if (ev_ones) begin
                    st_d.done  = 1'b1;
                    st_d.fail  = 1'b1;
                    st_d.state = ST_IDLE;
                end else if (!ev_busy) begin
                    if (st_q.mask == '0) begin
                        st_d.done  = 1'b1;
                        st_d.err   = ev_err;
                        st_d.state = ST_IDLE;
                    end else begin
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(SETTLE_US);
                        st_d.polls = '0;
                        st_d.state = ST_SETTLE2;
                    end
                end else if (pace_over) begin
                    st_d.done  = 1'b1;
                    st_d.fail  = 1'b1;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.elapsed = pace_next;
                    tmr_load     = 1'b1;
                    tmr_val      = pace_gap;
                    st_d.state   = ST_GAP;
                end
            end
            ST_RD_BITS: begin
                tf_rd = 1'b1;
                if (ev_match) begin
                    st_d.done  = 1'b1;
                    st_d.err   = ev_err;
                    st_d.state = ST_IDLE;
                end else if (st_q.polls == PW'(BIT_POLLS - 1)) begin
                    st_d.done  = 1'b1;
                    st_d.fail  = 1'b1;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.polls = st_q.polls + PW'(1);
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(BIT_STEP_US);
                    st_d.state = ST_GAP2;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wait_state_e state_q;
    logic        unit_q;
    assign state_q = st_q.state;
    assign unit_q  = st_q.unit;
    assign done    = st_q.done;
    assign fail    = st_q.fail;
    assign err_bit = st_q.err;
endmodule

// File: rtl/ata_status_waiter_chk.sv
module ata_status_waiter_chk
    import ata_wait_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        fail,
    input logic        err_bit,
    input logic        tf_rd,
    input logic        tf_wr,
    input logic [2:0]  tf_addr,
    input logic [7:0]  tf_wdata,
    input wait_state_e state,
    input logic        unit
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

    assert_fail_clears_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> !err_bit);

    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tf_rd && tf_wr));

    assert_rd_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tf_rd |-> (tf_addr == 3'd7));

    assert_resel_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> (tf_addr == 3'd6 && tf_wdata == {3'b101, unit, 4'b0000}));

    assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE1 && $past(state) != ST_SETTLE1) |-> $past(state) == ST_IDLE);
endmodule

bind ata_status_waiter ata_status_waiter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .fail     (fail),
    .err_bit  (err_bit),
    .tf_rd    (tf_rd),
    .tf_wr    (tf_wr),
    .tf_addr  (tf_addr),
    .tf_wdata (tf_wdata),
    .state    (state_q),
    .unit     (unit_q)
);

// File: tb/test_ata_status_waiter.sv
module test_ata_status_waiter;
    localparam int P_SETTLE = 1;
    localparam int P_RESEL  = 3;
    localparam int P_FAST   = 2;
    localparam int P_SLOW   = 5;
    localparam int P_LIMIT  = 6;
    localparam int P_BUDGET = 30;
    localparam int P_POLLS  = 4;
    localparam int P_BSTEP  = 2;

    localparam int K_READ = 0, K_WRITE = 1, K_DONE = 2;

    typedef struct {
        int    kind;
        int    a;
        int    b;
        string req;
    } exp_t;

    logic       clk = 0, rst_n = 0, tick_us = 0, start = 0, unit_sel = 0;
    logic [7:0] want_mask = 0;
    logic       done, fail, err_bit, tf_rd, tf_wr;
    logic [2:0] tf_addr;
    logic [7:0] tf_wdata, tf_rdata;
    logic       real_start = 0;

    int n_cmp = 0, n_bad = 0;
    exp_t exp_q[$];
    logic [7:0] scr[64];
    int scr_len = 1;
    int ridx = 0;
    int tcnt = 0;
    int tdiv = 0;

    always #10 clk = ~clk;

    ata_status_waiter #(
        .SETTLE_US(P_SETTLE), .RESEL_US(P_RESEL), .FAST_STEP_US(P_FAST),
        .SLOW_STEP_US(P_SLOW), .FAST_LIMIT_US(P_LIMIT), .BUSY_BUDGET_US(P_BUDGET),
        .BIT_POLLS(P_POLLS), .BIT_STEP_US(P_BSTEP)
    ) i_ata_status_waiter (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
        .want_mask(want_mask), .unit_sel(unit_sel), .done(done), .fail(fail),
        .err_bit(err_bit), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_addr(tf_addr),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
    );

    // device model: one scripted status value per read, the last one repeats
    assign tf_rdata = scr[(ridx < scr_len) ? ridx : scr_len - 1];

    always @(posedge clk) begin
        if (real_start) ridx <= 0;
        else if (tf_rd) ridx <= ridx + 1;
        tdiv    <= (tdiv == 2) ? 0 : tdiv + 1;
        tick_us <= (tdiv == 1);
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] scr_at(input int i);
        return scr[(i < scr_len) ? i : scr_len - 1];
    endfunction

    task automatic push(input int k, input int a, input int b, input string req);
        exp_t e;
        e.kind = k; e.a = a; e.b = b; e.req = req;
        exp_q.push_back(e);
    endtask

    // expected event list computed from the requirements
    task automatic model(input logic [7:0] mask, input logic u, input string req);
        int idx = 0;
        int el = 0;
        int gap;
        logic [7:0] s;
        push(K_READ, P_SETTLE, 0, req);
        while (1) begin
            s = scr_at(idx); idx++;
            if (s == 8'hFF) begin
                push(K_WRITE, 8'hA0 | (int'(u) << 4), 0, req);
                push(K_READ, P_RESEL, 0, req);
                s = scr_at(idx); idx++;
                if (s == 8'hFF) begin push(K_DONE, 1, 0, req); return; end
            end
            if (!s[7]) break;
            gap = (el > P_LIMIT) ? P_SLOW : P_FAST;
            el += gap;
            if (el >= P_BUDGET) begin push(K_DONE, 1, 0, req); return; end
            push(K_READ, gap, 0, req);
        end
        if (mask == 8'h00) begin push(K_DONE, 0, int'(s[0]), req); return; end
        push(K_READ, P_SETTLE, 0, req);
        for (int k = 0; k < P_POLLS; k++) begin
            s = scr_at(idx); idx++;
            if ((s & mask) == mask) begin push(K_DONE, 0, int'(s[0]), req); return; end
            if (k == P_POLLS - 1) begin push(K_DONE, 1, 0, req); return; end
            push(K_READ, P_BSTEP, 0, req);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (tf_rd || tf_wr || done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected event", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    if (tf_rd) begin
                        check(e.kind == K_READ, e.req, "read kind", K_READ, e.kind);
                        check(tcnt == e.a, e.req, "ticks before read", tcnt, e.a);
                        check(tf_addr == 3'd7, "R10", "read address", int'(tf_addr), 7);
                    end else if (tf_wr) begin
                        check(e.kind == K_WRITE, e.req, "write kind", K_WRITE, e.kind);
                        check(int'(tf_wdata) == e.a, e.req, "reselect data", int'(tf_wdata), e.a);
                        check(tf_addr == 3'd6, e.req, "reselect address", int'(tf_addr), 6);
                    end else begin
                        check(e.kind == K_DONE, e.req, "done kind", K_DONE, e.kind);
                        check(int'(fail) == e.a, e.req, "fail", int'(fail), e.a);
                        check(int'(err_bit) == e.b, e.req, "err_bit", int'(err_bit), e.b);
                    end
                end
            end
            if (tf_rd || tf_wr || real_start) tcnt = 0;
            else if (tick_us) tcnt++;
        end
    end

    task automatic load_script(input logic [7:0] v[], input logic [7:0] last);
        foreach (v[i]) scr[i] = v[i];
        scr[v.size()] = last;
        scr_len = v.size() + 1;
    endtask

    task automatic go(input logic [7:0] mask, input logic u, input string req);
        model(mask, u, req);
        @(posedge clk); #2;
        want_mask = mask; unit_sel = u; start = 1; real_start = 1;
        @(posedge clk); #2;
        start = 0; real_start = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin @(posedge clk); n++; end
        check(n < 5000, req, "watchdog: events still pending", exp_q.size(), 0);
        exp_q.delete();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #2000000;
        n_bad++;
        n_cmp++;
        $display("FAIL R9 global watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        scr[0] = 8'h50;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(!done && !fail && !err_bit && !tf_rd && !tf_wr, "R1", "outputs in reset",
              int'({done, fail, err_bit, tf_rd, tf_wr}), 0);
        rst_n = 1;
        repeat (3) @(posedge clk);

        // R2 R3: busy clears on third read, error bit set
        load_script('{8'h80, 8'h80}, 8'h51);
        go(8'h00, 0, "R3"); wait_idle("R3");
        load_script('{8'hD0}, 8'h50);
        go(8'h00, 0, "R2"); wait_idle("R2");

        // R4: fine to coarse spacing, clears on read 7
        load_script('{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80}, 8'h40);
        go(8'h00, 1, "R4"); wait_idle("R4");

        // R5: busy forever
        load_script('{8'h80}, 8'h80);
        go(8'h00, 0, "R5"); wait_idle("R5");

        // R6: one all-ones, recovers; then two all-ones
        load_script('{8'h80, 8'hFF}, 8'h50);
        go(8'h00, 1, "R6"); wait_idle("R6");
        load_script('{8'hFF}, 8'hFF);
        go(8'h00, 0, "R6"); wait_idle("R6");

        // R7: mask met on second poll with error bit
        load_script('{8'h80, 8'h40, 8'h40}, 8'h49);
        go(8'h48, 0, "R7"); wait_idle("R7");

        // R8: mask never met
        load_script('{8'h40}, 8'h40);
        go(8'h08, 1, "R8"); wait_idle("R8");

        // R9: start while running is ignored
        load_script('{8'h80, 8'h80, 8'h80}, 8'h51);
        go(8'h00, 0, "R9");
        repeat (5) @(posedge clk); #2;
        want_mask = 8'h08; start = 1;
        @(posedge clk); #2;
        start = 0;
        wait_idle("R9");
        check(!done && !tf_rd, "R9", "idle after ignored start", int'({done, tf_rd}), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule